// File: doc/BRIEF.md
# PWM Pair Output Polarity Stage

This block sits between a PWM timing generator and the pins. It takes three channel pairs. Each pair has a leading drive signal and a trailing drive signal, both active-high. The block turns them into pin values and per-pin output enables.

All three high-side pins share one configured idle level. All three low-side pins share another. A pin shows the inverse of its idle level while it is being driven active.

Each pair has a polarity selection that decides which pin carries the leading drive. A change of selection never takes effect at once. It waits for a reload strobe. In complementary mode it waits further, for the deadband-done strobe that follows that reload. This keeps a swap from cutting into a period or a dead time.

Output enables are separate per-pin signals. Pad logic can therefore leave a disabled pair undriven without a tristate inside the block.

Top module: `pwm_pol_stage`

## Requirements
- R1: Every high-side pin of an enabled pair shows `off_hi_i` while its drive is inactive.
- R2: Every low-side pin of an enabled pair shows `off_lo_i` while its drive is inactive.
- R3: A pin whose drive is active (drive bit 1) shows the inverse of its group's idle level.
- R4: With applied polarity 0 for a pair, the high-side pin follows `drv_hi_i` and the low-side pin follows `drv_lo_i`. With applied polarity 1, the high-side pin follows `drv_lo_i` and the low-side pin follows `drv_hi_i`, so the low side goes active first.
- R5: The applied polarity never changes the idle level of any pin.
- R6: Outside complementary mode, `pol_req_i` is applied on the clock edge that samples `reload_i` high. Without a reload, the applied polarity holds.
- R7: In complementary mode, a reload with a differing request defers the change. It is applied on the edge that samples `db_done_i` high after that reload.
- R8: A further complementary-mode reload while a change is pending replaces the pending value with the new request.
- R9: While `rst_ni` is low, the pins of enabled pairs show their idle levels with output enable 1. The applied polarity resets to 0.
- R10: For a pair whose enable bit is 0, both output enables are 0, at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| off_hi_i | input | 1 | Idle level of all high-side pins |
| off_lo_i | input | 1 | Idle level of all low-side pins |
| pair_en_i | input | 3 | Per-pair enable |
| pol_req_i | input | 3 | Requested polarity per pair |
| comp_mode_i | input | 1 | Complementary mode: defer swaps to deadband end |
| reload_i | input | 1 | Reload strobe |
| db_done_i | input | 1 | Deadband-ended strobe |
| drv_hi_i | input | 3 | Leading drive per pair, 1 = active |
| drv_lo_i | input | 3 | Trailing drive per pair, 1 = active |
| pin_hi_o | output | 3 | High-side pin values |
| pin_lo_o | output | 3 | Low-side pin values |
| oe_hi_o | output | 3 | High-side output enables |
| oe_lo_o | output | 3 | Low-side output enables |

## Verification
Idle levels are tried in both combinations of high-side and low-side settings, with all drives inactive and then with mixed drive patterns. This separates a wrong idle level from a missing inversion.

Polarity is set differently per pair, with one pair swapped and the others not, and every drive bit is set. This shows whether the swap routes to the right pair and the right pin, and that idle levels stay untouched.

Swap timing is checked in three ways: without a reload, across idle cycles in complementary mode, and at the deadband strobe. A second request placed over a pending one shows that replacement happens and that no queuing occurs.

// File: rtl/pwm_pol_pkg.sv
package pwm_pol_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } pin_pair_t;
endpackage

// File: rtl/pwm_pol_sched.sv
module pwm_pol_sched (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reload_i,
  input  logic db_done_i,
  input  logic comp_mode_i,
  input  logic pol_req_i,
  output logic pol_o
);
  logic pol_q, wait_q, wait_val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q      <= 1'b0;
      wait_q     <= 1'b0;
      wait_val_q <= 1'b0;
    end else if (reload_i) begin
      if (comp_mode_i) begin
        // newest request overwrites any pending one
        wait_q     <= (pol_req_i != pol_q);
        wait_val_q <= pol_req_i;
      end else begin
        pol_q  <= pol_req_i;
        wait_q <= 1'b0;
      end
    end else if (wait_q && db_done_i) begin
      pol_q  <= wait_val_q;
      wait_q <= 1'b0;
    end
  end

  assign pol_o = pol_q;

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload_i && !db_done_i) |=> $stable(pol_q));
  assert_direct_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_i && !comp_mode_i) |=> (pol_q == $past(pol_req_i)));
  assert_defer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_i && comp_mode_i) |=> $stable(pol_q));
  assert_replace_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q && db_done_i && !reload_i) |=> (pol_q == $past(wait_val_q)));
endmodule

// File: rtl/pwm_pin_drive.sv
module pwm_pin_drive
  import pwm_pol_pkg::*;
(
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      off_hi_i,
  input  logic      off_lo_i,
  input  logic      pol_i,
  input  pin_pair_t drv_i,
  output pin_pair_t pin_o,
  output pin_pair_t oe_o
);
  pin_pair_t act;

  always_comb begin
    act = pol_i ? '{hi: drv_i.lo, lo: drv_i.hi} : drv_i;
    if (!rst_ni || !en_i) act = '0;
    pin_o.hi = off_hi_i ^ act.hi;
    pin_o.lo = off_lo_i ^ act.lo;
    oe_o     = '{hi: en_i, lo: en_i};
  end

  always_comb begin
    if (rst_ni == 1'b0 && en_i == 1'b1)
      assert_reset_off_R9: assert (pin_o.hi == off_hi_i && pin_o.lo == off_lo_i);
    if (en_i == 1'b0)
      assert_disabled_hiz_R10: assert (oe_o == '0);
    if (rst_ni == 1'b1 && en_i == 1'b1 && drv_i == '0)
      assert_idle_level_R5: assert (pin_o.hi == off_hi_i && pin_o.lo == off_lo_i);
  end
endmodule

// File: rtl/pwm_pol_stage.sv
module pwm_pol_stage
  import pwm_pol_pkg::*;
#(
  parameter int NUM_PAIRS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 off_hi_i,
  input  logic                 off_lo_i,
  input  logic [NUM_PAIRS-1:0] pair_en_i,
  input  logic [NUM_PAIRS-1:0] pol_req_i,
  input  logic                 comp_mode_i,
  input  logic                 reload_i,
  input  logic                 db_done_i,
  input  logic [NUM_PAIRS-1:0] drv_hi_i,
  input  logic [NUM_PAIRS-1:0] drv_lo_i,
  output logic [NUM_PAIRS-1:0] pin_hi_o,
  output logic [NUM_PAIRS-1:0] pin_lo_o,
  output logic [NUM_PAIRS-1:0] oe_hi_o,
  output logic [NUM_PAIRS-1:0] oe_lo_o
);
  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    logic      pol;
    pin_pair_t pin, oe;

    pwm_pol_sched u_sched (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .reload_i    (reload_i),
      .db_done_i   (db_done_i),
      .comp_mode_i (comp_mode_i),
      .pol_req_i   (pol_req_i[i]),
      .pol_o       (pol)
    );

    pwm_pin_drive u_drive (
      .rst_ni   (rst_ni),
      .en_i     (pair_en_i[i]),
      .off_hi_i (off_hi_i),
      .off_lo_i (off_lo_i),
      .pol_i    (pol),
      .drv_i    ('{hi: drv_hi_i[i], lo: drv_lo_i[i]}),
      .pin_o    (pin),
      .oe_o     (oe)
    );

    assign pin_hi_o[i] = pin.hi;
    assign pin_lo_o[i] = pin.lo;
    assign oe_hi_o[i]  = oe.hi;
    assign oe_lo_o[i]  = oe.lo;
  end
endmodule

// File: tb/pwm_pol_stage_bench.sv
module pwm_pol_stage_bench;
  localparam int N = 3;
  logic clk = 0, rst_ni = 0;
  logic off_hi = 1, off_lo = 0, comp = 0, reload = 0, db_done = 0;
  logic [N-1:0] en = '0, pol_req = '0, drv_hi = '0, drv_lo = '0;
  logic [N-1:0] pin_hi, pin_lo, oe_hi, oe_lo;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_pol_stage #(.NUM_PAIRS(N)) u_pwm_pol_stage (
    .clk_i(clk), .rst_ni(rst_ni), .off_hi_i(off_hi), .off_lo_i(off_lo),
    .pair_en_i(en), .pol_req_i(pol_req), .comp_mode_i(comp),
    .reload_i(reload), .db_done_i(db_done), .drv_hi_i(drv_hi), .drv_lo_i(drv_lo),
    .pin_hi_o(pin_hi), .pin_lo_o(pin_lo), .oe_hi_o(oe_hi), .oe_lo_o(oe_lo));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected pins from requirements, given the polarity the bench believes applied
  task automatic chk_pins(string tag, logic [N-1:0] pol);
    logic [N-1:0] eh, el;
    for (int i = 0; i < N; i++) begin
      logic ah, al;
      ah = pol[i] ? drv_lo[i] : drv_hi[i];
      al = pol[i] ? drv_hi[i] : drv_lo[i];
      if (!rst_ni || !en[i]) begin ah = 0; al = 0; end
      eh[i] = off_hi ^ ah;
      el[i] = off_lo ^ al;
    end
    #1;
    chk({tag, " hi"}, 16'(pin_hi), 16'(eh));
    chk({tag, " lo"}, 16'(pin_lo), 16'(el));
  endtask

  task automatic step(); @(posedge clk); #1; endtask

  task automatic pulse_reload(); reload = 1; step(); reload = 0; endtask
  task automatic pulse_db(); db_done = 1; step(); db_done = 0; endtask

  task automatic t_reset();
    en = 3'b011; drv_hi = '1; drv_lo = '1; off_hi = 1; off_lo = 0;
    step();
    chk_pins("R9 reset off", 3'b000);
    chk("R9 reset oe_hi", 16'(oe_hi), 16'(3'b011));
    chk("R10 reset oe_lo", 16'(oe_lo), 16'(3'b011));
  endtask

  task automatic t_levels();
    rst_ni = 1; en = '1; drv_hi = '0; drv_lo = '0; step();
    off_hi = 0; off_lo = 1; chk_pins("R1 R2 idle 0/1", 3'b000);
    off_hi = 1; off_lo = 0; chk_pins("R1 R2 idle 1/0", 3'b000);
    drv_hi = 3'b101; drv_lo = 3'b010; chk_pins("R3 active 1/0", 3'b000);
    off_hi = 0; off_lo = 1; chk_pins("R3 active 0/1", 3'b000);
  endtask

  task automatic t_swap();
    comp = 0; pol_req = 3'b010; drv_hi = '1; drv_lo = '0;
    step(); step();
    chk_pins("R6 no reload hold", 3'b000);
    pulse_reload();
    chk_pins("R4 R6 swap pair1", 3'b010);
    drv_hi = '0; chk_pins("R5 idle after swap", 3'b010);
    drv_lo = '1; chk_pins("R4 trail drive", 3'b010);
  endtask

  task automatic t_comp();
    comp = 1; pol_req = 3'b110; drv_hi = 3'b111; drv_lo = 3'b000;
    pulse_reload();
    chk_pins("R7 deferred at reload", 3'b010);
    step(); step();
    chk_pins("R7 still deferred", 3'b010);
    pulse_db();
    chk_pins("R7 applied at deadband", 3'b110);
  endtask

  task automatic t_replace();
    comp = 1; pol_req = 3'b001; pulse_reload();
    pol_req = 3'b100; pulse_reload();
    chk_pins("R8 pending", 3'b110);
    pulse_db();
    chk_pins("R8 replaced value", 3'b100);
    comp = 0; pol_req = 3'b000; pulse_reload();
  endtask

  task automatic t_disable();
    en = 3'b101; drv_hi = '1; drv_lo = 3'b010;
    #1;
    chk("R10 oe_hi", 16'(oe_hi), 16'(3'b101));
    chk("R10 oe_lo", 16'(oe_lo), 16'(3'b101));
    chk_pins("R10 pins", 3'b000);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_levels(); t_swap(); t_comp(); t_replace(); t_disable();
        done = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog act=hung exp=done");
        end
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule